// File: doc/BRIEF.md
# Half-Duplex Differential-Line UART

This block is a serial port for a two-wire differential transceiver that can either drive the pair or listen to it, but never both at once. Software programs the bit rate through a 16-bit divisor, chooses none, even or odd parity, and chooses one or two stop bits. Bytes for transmission go into a small holding queue. Received bytes are held in a one-deep register together with their parity and framing flags. All access goes through a byte-wide register port.

The channel starts out listening after reset. Software sets a direction bit to turn it into a talker. In that mode the block raises the transceiver driver enable and sends queued bytes back to back. When software clears the direction bit, the character currently on the wire finishes through its last stop bit. Only then does the driver enable drop, and bytes still queued stay unsent. While the channel talks, the receiver is held idle and ignores the line. The receiver oversamples at 16 times the bit rate and confirms each start bit at its midpoint. It only accepts a new start after it has seen the line high.

Register map (addr): 0 DATA (write queues a byte, read returns the received byte and consumes it), 1 CTRL, 2 divisor low byte, 3 divisor high byte, 4 STATUS.

Top module: `hd_uart485`

## Requirements
- R1: After reset de_o is 0, tx_o is 1, STATUS (addr 4) and CTRL (addr 1) read 0x00, and the divisor reads 0x01 at addr 2 and 0x00 at addr 3.
- R2: A transmitted character is one low start bit, then 8 data bits LSB first, then the stop bits driven high. Each bit lasts 16*(D+1) clocks, where D is the divisor in addr 3:addr 2.
- R3: CTRL[2:1] selects the parity: 00 none, 01 even, 10 odd, 11 none. When parity is used, the parity bit follows bit 7 in both directions.
- R4: CTRL[3]=1 selects two stop bits and CTRL[3]=0 selects one. Queued bytes go out back to back, so consecutive start edges are (9 + parity bits + stop bits) bit times apart.
- R5: Writing CTRL[0]=1 enters transmit mode. de_o is 1 only in transmit mode, and tx_o is 1 whenever de_o is 0.
- R6: Clearing CTRL[0] while a character is on the wire keeps de_o at 1 until its last stop bit ends. de_o then falls, and no further queued byte is sent.
- R7: A start is accepted only if the line is still low at the midpoint of the start bit, and only after the line has been seen high since the previous frame. A short low glitch and a line held low after a frame produce no byte.
- R8: Each received byte sets STATUS[0] and stores the data with STATUS[1] (parity mismatch) and STATUS[2] (a stop bit sampled low).
- R9: While in transmit mode the receiver ignores the line, and no byte is received.
- R10: The transmit queue holds 4 bytes. STATUS[3] reads 1 when it is full, and a DATA write to a full queue is dropped. STATUS[4] is 1 while a character is being shifted out, and STATUS[5] is 1 in transmit mode.
- R11: Reading DATA clears STATUS[0]. STATUS[1] and STATUS[2] read 0 while STATUS[0] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (consumes received byte at addr 0) |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid in the same cycle as addr |
| rx_i | input | 1 | Receive data from the transceiver |
| tx_o | output | 1 | Transmit data to the transceiver |
| de_o | output | 1 | Transceiver driver enable |

## Verification
The bench goes after the direction change in the middle of a character. A design that drops the enable at once truncates the stop bit, and one that keeps draining the queue sends an extra byte. It measures start-to-start spacing under each parity and stop setting, so a miscounted stop or parity slot shows up as a wrong interval. On the receive side it drives a short glitch, a frame with a bad stop bit, a wrong parity bit, and a long break. A receiver that skips the midpoint check or re-arms on a low line reports phantom bytes. It also drives a frame while the channel is talking, which catches a receiver that is not gated off in transmit mode.

// File: rtl/hd_uart_pkg.sv
package hd_uart_pkg;

    localparam int unsigned OVERSAMPLE = 16;
    localparam int unsigned BYTE_W     = 8;

    localparam logic [2:0] REG_DATA  = 3'd0;
    localparam logic [2:0] REG_CTRL  = 3'd1;
    localparam logic [2:0] REG_DIVLO = 3'd2;
    localparam logic [2:0] REG_DIVHI = 3'd3;
    localparam logic [2:0] REG_STAT  = 3'd4;

    typedef enum logic [1:0] {
        PAR_NONE     = 2'd0,
        PAR_EVEN     = 2'd1,
        PAR_ODD      = 2'd2,
        PAR_NONE_ALT = 2'd3
    } parity_e;

    typedef struct packed {
        logic    two_stop;
        parity_e par;
        logic    tx_req;
    } ctrl_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_word_t;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PAR,
        FR_STOP
    } frame_e;

    function automatic logic par_used(parity_e p);
        return (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    function automatic logic par_bit(logic [BYTE_W-1:0] d, parity_e p);
        return (p == PAR_ODD) ? ~^d : ^d;
    endfunction

endpackage

// File: rtl/hd_baud_tick.sv
module hd_baud_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (cnt >= div) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = (cnt >= div);
endmodule

// File: rtl/hd_txq.sv
module hd_txq #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/hd_tx_serializer.sv
module hd_tx_serializer
    import hd_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  parity_e           par,
    input  logic              two_stop,
    output logic              line,
    output logic              busy
);
    localparam logic [3:0] SUB_LAST = 4'(OVERSAMPLE - 1);

    frame_e            st;
    logic [3:0]        sub;
    logic [2:0]        bitn;
    logic [BYTE_W-1:0] sh;
    logic              pbit, use_par, extra_stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= FR_IDLE;
            sub        <= '0;
            bitn       <= '0;
            sh         <= '0;
            pbit       <= 1'b0;
            use_par    <= 1'b0;
            extra_stop <= 1'b0;
        end else if (st == FR_IDLE) begin
            if (load) begin
                st         <= FR_START;
                sub        <= '0;
                bitn       <= '0;
                sh         <= din;
                pbit       <= par_bit(din, par);
                use_par    <= par_used(par);
                extra_stop <= two_stop;
            end
        end else if (tick) begin
            sub <= sub + 4'd1;
            if (sub == SUB_LAST) begin
                if (st == FR_START) begin
                    st <= FR_DATA;
                end else if (st == FR_DATA) begin
                    sh   <= sh >> 1;
                    bitn <= bitn + 3'd1;
                    if (bitn == 3'd7) st <= use_par ? FR_PAR : FR_STOP;
                end else if (st == FR_PAR) begin
                    st <= FR_STOP;
                end else if (extra_stop) begin
                    extra_stop <= 1'b0;
                end else begin
                    st <= FR_IDLE;
                end
            end
        end
    end

    always_comb begin
        case (st)
            FR_START: line = 1'b0;
            FR_DATA:  line = sh[0];
            FR_PAR:   line = pbit;
            default:  line = 1'b1;
        endcase
    end

    assign busy = (st != FR_IDLE);
endmodule

// File: rtl/hd_rx_sampler.sv
module hd_rx_sampler
    import hd_uart_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     en,
    input  logic     rxd,
    input  parity_e  par,
    input  logic     two_stop,
    output logic     done,
    output rx_word_t word
);
    localparam logic [3:0] SUB_LAST = 4'(OVERSAMPLE - 1);
    localparam logic [3:0] SUB_MID  = 4'(OVERSAMPLE / 2 - 1);

    frame_e            st;
    logic [3:0]        sub;
    logic [2:0]        bitn;
    logic [BYTE_W-1:0] sh;
    logic              perr, ferr, extra_stop, armed;
    parity_e           par_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st         <= FR_IDLE;
            sub        <= '0;
            bitn       <= '0;
            sh         <= '0;
            perr       <= 1'b0;
            ferr       <= 1'b0;
            extra_stop <= 1'b0;
            armed      <= 1'b0;
            par_q      <= PAR_NONE;
        end else begin
            case (st)
                FR_IDLE: begin
                    if (rxd) armed <= 1'b1;
                    if (tick && !rxd && armed) begin
                        st         <= FR_START;
                        sub        <= '0;
                        armed      <= 1'b0;
                        par_q      <= par;
                        extra_stop <= two_stop;
                    end
                end
                FR_START: if (tick) begin
                    sub <= sub + 4'd1;
                    if (sub == SUB_MID) begin
                        sub <= '0;
                        if (!rxd) begin
                            st   <= FR_DATA;
                            bitn <= '0;
                            perr <= 1'b0;
                            ferr <= 1'b0;
                        end else begin
                            st <= FR_IDLE;
                        end
                    end
                end
                FR_DATA: if (tick) begin
                    sub <= sub + 4'd1;
                    if (sub == SUB_LAST) begin
                        sh   <= {rxd, sh[BYTE_W-1:1]};
                        bitn <= bitn + 3'd1;
                        if (bitn == 3'd7) st <= par_used(par_q) ? FR_PAR : FR_STOP;
                    end
                end
                FR_PAR: if (tick) begin
                    sub <= sub + 4'd1;
                    if (sub == SUB_LAST) begin
                        perr <= (rxd != par_bit(sh, par_q));
                        st   <= FR_STOP;
                    end
                end
                default: if (tick) begin
                    sub <= sub + 4'd1;
                    if (sub == SUB_LAST) begin
                        if (!rxd) ferr <= 1'b1;
                        if (extra_stop) extra_stop <= 1'b0;
                        else            st <= FR_IDLE;
                    end
                end
            endcase
        end
    end

    assign done = en && (st == FR_STOP) && tick && (sub == SUB_LAST) && !extra_stop;
    assign word = '{data: sh, perr: perr, ferr: ferr | !rxd};
endmodule

// File: rtl/hd_uart485.sv
module hd_uart485
    import hd_uart_pkg::*;
#(
    parameter int               DIV_W       = 16,
    parameter int               TXQ_DEPTH   = 4,
    parameter int               SYNC_STAGES = 2,
    parameter logic [DIV_W-1:0] DIV_RESET   = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       rx_i,
    output logic       tx_o,
    output logic       de_o
);
    localparam int QCW = $clog2(TXQ_DEPTH + 1);

    ctrl_t                  ctrl_q;
    logic [DIV_W-1:0]       div_q;
    logic                   mode_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rxd;
    logic                   rx_valid_q;
    rx_word_t               rx_q, rx_w;
    logic                   rx_done;
    logic                   tick;
    logic                   tx_line, tx_busy, tx_load;
    logic [BYTE_W-1:0]      q_dout;
    logic                   q_empty, q_full;
    logic [QCW-1:0]         q_cnt;
    logic                   q_push;
    logic [7:0]             status;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= DIV_RESET;
        end else if (wr_en) begin
            case (addr)
                REG_CTRL:  ctrl_q <= ctrl_t'(wr_data[3:0]);
                REG_DIVLO: div_q[7:0] <= wr_data;
                REG_DIVHI: div_q[DIV_W-1:8] <= wr_data[DIV_W-9:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 mode_q <= 1'b0;
        else if (ctrl_q.tx_req)  mode_q <= 1'b1;
        else if (!tx_busy)       mode_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
    end
    assign rxd = sync_q[SYNC_STAGES-1];

    hd_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk (clk),
        .rst (rst),
        .div (div_q),
        .tick(tick)
    );

    assign q_push  = wr_en && (addr == REG_DATA);
    assign q_full  = (q_cnt == QCW'(TXQ_DEPTH));
    assign tx_load = mode_q && ctrl_q.tx_req && !q_empty && !tx_busy;

    hd_txq #(.DEPTH(TXQ_DEPTH), .W(BYTE_W)) u_txq (
        .clk  (clk),
        .rst  (rst),
        .push (q_push),
        .pop  (tx_load),
        .din  (wr_data),
        .dout (q_dout),
        .empty(q_empty),
        .count(q_cnt)
    );

    hd_tx_serializer u_tx (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .load    (tx_load),
        .din     (q_dout),
        .par     (ctrl_q.par),
        .two_stop(ctrl_q.two_stop),
        .line    (tx_line),
        .busy    (tx_busy)
    );

    hd_rx_sampler u_rx (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .en      (!mode_q),
        .rxd     (rxd),
        .par     (ctrl_q.par),
        .two_stop(ctrl_q.two_stop),
        .done    (rx_done),
        .word    (rx_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid_q <= 1'b0;
            rx_q       <= '0;
        end else if (rx_done) begin
            rx_valid_q <= 1'b1;
            rx_q       <= rx_w;
        end else if (rd_en && (addr == REG_DATA)) begin
            rx_valid_q <= 1'b0;
        end
    end

    assign status = {2'b00, mode_q, tx_busy, q_full,
                     rx_q.ferr & rx_valid_q, rx_q.perr & rx_valid_q, rx_valid_q};

    always_comb begin
        case (addr)
            REG_DATA:  rd_data = rx_q.data;
            REG_CTRL:  rd_data = {4'b0000, ctrl_q};
            REG_DIVLO: rd_data = div_q[7:0];
            REG_DIVHI: rd_data = 8'(div_q >> 8);
            REG_STAT:  rd_data = status;
            default:   rd_data = 8'h00;
        endcase
    end

    assign de_o = mode_q;
    assign tx_o = mode_q ? tx_line : 1'b1;
endmodule

// File: rtl/hd_uart485_chk.sv
module hd_uart485_chk #(
    parameter int TXQ_DEPTH = 4,
    parameter int QCW       = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           de,
    input logic           txd,
    input logic           tx_busy,
    input logic           rx_valid,
    input logic [QCW-1:0] q_count
);
    assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> (!de && txd));

    assert_line_idle_R5: assert property (@(posedge clk) disable iff (rst) !de |-> txd);

    assert_hold_enable_R6: assert property (@(posedge clk) disable iff (rst)
        (de && tx_busy) |=> de);

    assert_rx_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        de |=> !$rose(rx_valid));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        q_count <= QCW'(TXQ_DEPTH));
endmodule

bind hd_uart485 hd_uart485_chk #(
    .TXQ_DEPTH(TXQ_DEPTH),
    .QCW      ($clog2(TXQ_DEPTH + 1))
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .de      (de_o),
    .txd     (tx_o),
    .tx_busy (tx_busy),
    .rx_valid(rx_valid_q),
    .q_count (q_cnt)
);

// File: tb/hd_uart485_tb.sv
module hd_uart485_tb;
    localparam int DIVV = 1;
    localparam int BITC = 16 * (DIVV + 1);
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       rx_i = 1'b1;
    logic       tx_o, de_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int         mon_par = 0;
    int         mon_stops = 1;
    logic [7:0] exp_q[$];
    int         starts[$];
    int         frames_seen = 0;
    bit         in_frame = 0;

    hd_uart485 u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .rx_i(rx_i), .tx_o(tx_o), .de_o(de_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == WATCHDOG) begin
            chk(1'b0, "watchdog expired", cyc, WATCHDOG);
            finish_run();
        end
    end

    // R5: the line is never driven low while the enable is off
    always @(negedge clk) begin
        if (!rst) chk(de_o || (tx_o === 1'b1), "R5 line idle without enable", tx_o, 1);
    end

    // Behavioural line model: decodes every frame and compares with the queue of expected bytes
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && de_o === 1'b1 && tx_o === 1'b0) begin
                logic [7:0] got;
                logic [7:0] want;
                in_frame = 1;
                starts.push_back(cyc);
                repeat (BITC / 2) @(negedge clk);
                chk(tx_o === 1'b0, "R2 start bit", tx_o, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BITC) @(negedge clk);
                    got[i] = tx_o;
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 R10 unexpected frame", got, 0);
                    want = got;
                end else begin
                    want = exp_q.pop_front();
                end
                chk(got == want, "R2 data bits", got, want);
                if (mon_par != 0) begin
                    repeat (BITC) @(negedge clk);
                    chk(tx_o === ((mon_par == 1) ? ^want : ~^want), "R3 parity bit",
                        tx_o, (mon_par == 1) ? ^want : ~^want);
                end
                for (int s = 0; s < mon_stops; s++) begin
                    repeat (BITC) @(negedge clk);
                    chk(tx_o === 1'b1, "R4 stop bit", tx_o, 1);
                end
                frames_seen++;
                in_frame = 0;
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        exp_q.delete();
        mon_par = 0;
        mon_stops = 1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input int par, input int stops,
                              input bit bad_par, input bit bad_stop);
        @(negedge clk);
        rx_i = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_i = d[i];
            repeat (BITC) @(negedge clk);
        end
        if (par != 0) begin
            rx_i = ((par == 1) ? ^d : ~^d) ^ bad_par;
            repeat (BITC) @(negedge clk);
        end
        for (int s = 0; s < stops; s++) begin
            rx_i = !bad_stop;
            repeat (BITC) @(negedge clk);
        end
        rx_i = 1'b1;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic check_gap(input int nbits, input string tag);
        int n;
        int d;
        n = starts.size();
        d = starts[n-1] - starts[n-2];
        chk(d >= nbits * BITC - 1 && d <= nbits * BITC + 1, tag, d, nbits * BITC);
    endtask

    task automatic rx_expect(input logic [7:0] st, input logic [7:0] d, input string tag);
        logic [7:0] v;
        rd(3'd4, v);
        chk(v == st, {tag, " status"}, v, st);
        rd(3'd0, v);
        chk(v == d, {tag, " data"}, v, d);
        rd(3'd4, v);
        chk(v == 8'h00, "R11 status cleared by data read", v, 0);
    endtask

    initial begin
        logic [7:0] v;
        int base;

        // R1 reset state
        do_reset();
        chk(de_o == 1'b0, "R1 enable after reset", de_o, 0);
        chk(tx_o == 1'b1, "R1 line after reset", tx_o, 1);
        rd(3'd4, v); chk(v == 8'h00, "R1 status after reset", v, 0);
        rd(3'd1, v); chk(v == 8'h00, "R1 ctrl after reset", v, 0);
        rd(3'd2, v); chk(v == 8'h01, "R1 divisor low after reset", v, 1);
        rd(3'd3, v); chk(v == 8'h00, "R1 divisor high after reset", v, 0);

        // R2 and R4: no parity, one stop bit
        wr(3'd2, 8'(DIVV));
        wr(3'd3, 8'h00);
        base = frames_seen;
        wr(3'd0, 8'hA5); exp_q.push_back(8'hA5);
        wr(3'd0, 8'h3C); exp_q.push_back(8'h3C);
        wr(3'd1, 8'h01);
        repeat (4) @(negedge clk);
        chk(de_o == 1'b1, "R5 enable in transmit mode", de_o, 1);
        wait (frames_seen == base + 2);
        check_gap(10, "R4 one stop spacing");
        repeat (BITC) @(negedge clk);

        // R3 even parity, R4 two stop bits
        mon_par = 1; mon_stops = 2;
        wr(3'd1, 8'h0B);
        base = frames_seen;
        wr(3'd0, 8'h07); exp_q.push_back(8'h07);
        wr(3'd0, 8'h81); exp_q.push_back(8'h81);
        wait (frames_seen == base + 2);
        check_gap(12, "R4 two stop spacing with parity");
        repeat (2 * BITC) @(negedge clk);

        // R3 odd parity, one stop
        mon_par = 2; mon_stops = 1;
        wr(3'd1, 8'h05);
        base = frames_seen;
        wr(3'd0, 8'h00); exp_q.push_back(8'h00);
        wr(3'd0, 8'hFF); exp_q.push_back(8'hFF);
        wait (frames_seen == base + 2);
        check_gap(11, "R3 odd parity spacing");
        repeat (BITC) @(negedge clk);

        // R10 queue depth and full flag
        mon_par = 0;
        wr(3'd1, 8'h00);
        repeat (4) @(negedge clk);
        chk(de_o == 1'b0, "R5 enable off in receive mode", de_o, 0);
        for (int i = 0; i < 5; i++) begin
            wr(3'd0, 8'(8'h11 + i));
            if (i < 4) exp_q.push_back(8'(8'h11 + i));
        end
        rd(3'd4, v); chk(v == 8'h08, "R10 full flag with idle channel", v, 8'h08);
        base = frames_seen;
        wr(3'd1, 8'h01);
        wait (frames_seen == base + 4);
        repeat (3 * BITC) @(negedge clk);
        chk(frames_seen == base + 4, "R10 dropped write not sent", frames_seen - base, 4);
        rd(3'd4, v); chk(v == 8'h20, "R10 status after drain", v, 8'h20);

        // R6 direction change in the middle of a character
        base = frames_seen;
        wr(3'd0, 8'h5A); exp_q.push_back(8'h5A);
        wr(3'd0, 8'h69);
        wait (in_frame);
        wr(3'd1, 8'h00);
        wait (frames_seen == base + 1);
        chk(de_o == 1'b1, "R6 enable held through stop bit", de_o, 1);
        repeat (BITC) @(negedge clk);
        chk(de_o == 1'b0, "R6 enable released after stop", de_o, 0);
        repeat (3 * BITC) @(negedge clk);
        chk(frames_seen == base + 1, "R6 queued byte not sent", frames_seen - base, 1);

        // R9 receiver ignores the line while talking
        do_reset();
        wr(3'd1, 8'h01);
        repeat (4) @(negedge clk);
        send_frame(8'h33, 0, 1, 0, 0);
        rd(3'd4, v); chk(v[0] == 1'b0, "R9 no byte in transmit mode", v, 8'h20);
        wr(3'd1, 8'h00);
        repeat (4 * BITC) @(negedge clk);

        // R8 clean receive
        send_frame(8'hC3, 0, 1, 0, 0);
        rx_expect(8'h01, 8'hC3, "R8 clean byte");

        // R8 parity error with even parity
        wr(3'd1, 8'h02);
        send_frame(8'h07, 1, 1, 1, 0);
        rx_expect(8'h03, 8'h07, "R8 parity error");

        // R3 odd parity, two stops, received clean
        wr(3'd1, 8'h0C);
        send_frame(8'h96, 2, 2, 0, 0);
        rx_expect(8'h01, 8'h96, "R3 odd parity receive");

        // R8 framing error
        wr(3'd1, 8'h00);
        send_frame(8'h55, 0, 1, 0, 1);
        repeat (2 * BITC) @(negedge clk);
        rx_expect(8'h05, 8'h55, "R8 framing error");

        // R7 short glitch
        @(negedge clk); rx_i = 1'b0;
        repeat (4) @(negedge clk); rx_i = 1'b1;
        repeat (12 * BITC) @(negedge clk);
        rd(3'd4, v); chk(v == 8'h00, "R7 glitch rejected", v, 0);

        // R7 long break: one byte with framing error, then nothing more
        @(negedge clk); rx_i = 1'b0;
        repeat (14 * BITC) @(negedge clk); rx_i = 1'b1;
        repeat (12 * BITC) @(negedge clk);
        rx_expect(8'h05, 8'h00, "R7 break yields single byte");
        repeat (12 * BITC) @(negedge clk);
        rd(3'd4, v); chk(v == 8'h00, "R7 no byte after break", v, 0);

        finish_run();
    end
endmodule